// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block is the interrupt acceptance core that sits beside one processor. It keeps three 256-bit vectors: requests waiting for service, vectors the processor is currently servicing, and the trigger kind (edge or level) of each request. Deliveries arrive as a vector number plus a trigger flag. The block compares the best pending request against a processor priority and raises a single interrupt line when the request wins.

The processor drives three handshakes. An acknowledge returns a vector number in the same cycle and moves that request into service. An end-of-interrupt retires the highest vector in service. A write to the 4-bit task-priority port sets a software priority floor. A 9-bit spurious register holds the vector returned when an acknowledge is refused, and its top bit is the software enable. An initialisation command puts the block back into its disabled starting state.

Top module: `vec_prio_core`

## Requirements
- R1: A delivery (`dlvValid`=1) sets request bit `dlvVector`. It records the trigger kind: `dlvLevel`=1 means level and 0 means edge. During an acknowledge that returns a real vector, `ackLevel` shows the trigger kind recorded for that vector. In every other case `ackLevel` is 0.
- R2: The best pending request is the highest-numbered set request bit. An acknowledge with no request pending returns `svrOut[7:0]` and changes no state.
- R3: `intOut` is 1 only when `svrOut[8]`=1 and a request is pending. When `pprOut` is nonzero, bits 7:4 of the best request must also be strictly greater than `pprOut[7:4]`.
- R4: On an acknowledge with a request pending, the best request bit is cleared. If `tprOut` is nonzero and the vector is less than or equal to `tprOut`, `ackVector` is `svrOut[7:0]`. Otherwise `ackVector` is the vector and its in-service bit is set.
- R5: An end-of-interrupt clears the highest set in-service bit. With nothing in service it has no effect.
- R6: `tprWrEn` stores `tprWrData` into bits 7:4 of the task priority, and bits 3:0 become 0.
- R7: `initReq` clears all three vectors and the task priority, and sets the spurious register to 0x0FF, which disables the block. It overrides every other input in the same cycle.
- R8: `pprOut` equals `tprOut` when `tprOut[7:4]` is greater than or equal to bits 7:4 of the highest in-service vector, or when nothing is in service. Otherwise it equals that in-service class with bits 3:0 zero.
- R9: Some requests arrive in the same cycle. A delivery to the vector being acknowledged leaves its request bit set. An end-of-interrupt uses the in-service state from before that cycle's acknowledge.
- R10: `svrWrEn` loads all 9 bits of `svrWrData` into the spurious register. Bit 8 is the enable.
- R11: After reset, `intOut`=0, `tprOut`=0, `pprOut`=0 and `svrOut`=0x0FF, with all vectors empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dlvValid | input | 1 | Delivery strobe |
| dlvVector | input | 8 | Delivered vector number |
| dlvLevel | input | 1 | 1 = level-triggered delivery, 0 = edge |
| ackReq | input | 1 | Acknowledge strobe from the processor |
| ackVector | output | 8 | Vector returned for an acknowledge (same cycle) |
| ackLevel | output | 1 | Trigger kind of the acknowledged vector |
| eoiReq | input | 1 | End-of-interrupt strobe |
| tprWrEn | input | 1 | Task-priority write strobe |
| tprWrData | input | 4 | Task-priority class to store |
| svrWrEn | input | 1 | Spurious register write strobe |
| svrWrData | input | 9 | Spurious register value, bit 8 = enable |
| initReq | input | 1 | Initialisation command |
| intOut | output | 1 | Interrupt line to the processor |
| tprOut | output | 8 | Current task priority |
| pprOut | output | 8 | Current processor priority |
| svrOut | output | 9 | Current spurious register |

## Verification
The assertions check invariants on every cycle. The interrupt line never rises while the block is disabled or has no request. The processor priority never falls below the task priority, and the low nibble of the task priority stays zero. A delivered bit, an acknowledged bit and a retired in-service bit each reach the state one cycle later, and initialisation leaves all vectors empty. Only the bench scenarios can show the ordering results. These are the class comparison at its boundary, the spurious return when the vector equals the task priority, delivery and acknowledge on the same vector, and the nesting of in-service levels across mixed random traffic checked against an independent model.

// File: rtl/vec_prio_pkg.sv
package vec_prio_pkg;
  typedef struct packed {
    logic init;
    logic dlvDo;
    logic ackTake;
    logic ackToIsr;
    logic eoiDo;
  } strobe_t;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int NUM_VEC = 256,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] bitsIn,
  output logic [IDX_W-1:0]   topIdx,
  output logic               anySet
);
  always_comb begin
    topIdx = '0;
    anySet = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (bitsIn[i]) begin
        topIdx = IDX_W'(i);
        anySet = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_prio_dp.sv
module vec_prio_dp
  import vec_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  localparam int IDX_W = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [IDX_W-1:0] dlvVector,
  input  logic             dlvLevel,
  output logic [IDX_W-1:0] irrTop,
  output logic             irrValid,
  output logic [IDX_W-1:0] isrTop,
  output logic             isrValid,
  output logic             topLevel
);
  logic [NUM_VEC-1:0] irrVec, isrVec, tmrVec;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;

  vec_prio_enc #(.NUM_VEC(NUM_VEC)) u_irrEnc (.bitsIn(irrVec), .topIdx(irrTop), .anySet(irrValid));
  vec_prio_enc #(.NUM_VEC(NUM_VEC)) u_isrEnc (.bitsIn(isrVec), .topIdx(isrTop), .anySet(isrValid));

  assign topLevel = tmrVec[irrTop];

  // Acknowledge clears first, then the delivery sets; EOI clears before the ack's in-service set.
  always_comb begin
    irrNext = irrVec;
    isrNext = isrVec;
    tmrNext = tmrVec;
    if (strb.ackTake)  irrNext[irrTop] = 1'b0;
    if (strb.eoiDo)    isrNext[isrTop] = 1'b0;
    if (strb.ackToIsr) isrNext[irrTop] = 1'b1;
    if (strb.dlvDo) begin
      irrNext[dlvVector] = 1'b1;
      tmrNext[dlvVector] = dlvLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.init) begin
      irrVec <= '0;
      isrVec <= '0;
      tmrVec <= '0;
    end else begin
      irrVec <= irrNext;
      isrVec <= isrNext;
      tmrVec <= tmrNext;
    end
  end

  AST_DLV_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.dlvDo && !strb.init |=> irrVec[$past(dlvVector)] && (tmrVec[$past(dlvVector)] == $past(dlvLevel))); // R1
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake && !strb.init && !(strb.dlvDo && dlvVector == irrTop) |=> !irrVec[$past(irrTop)]); // R4
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.eoiDo && !strb.init && !(strb.ackToIsr && irrTop == isrTop) |=> !isrVec[$past(isrTop)]); // R5
  AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.init |=> !irrValid && !isrValid && (tmrVec == '0)); // R7
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vec_prio_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLASS_LSB = 4,
  localparam int TPR_IN_W = VEC_W - CLASS_LSB,
  localparam int SVR_W = VEC_W + 1,
  localparam logic [VEC_W-1:0] CLS_MASK = ~VEC_W'((1 << CLASS_LSB) - 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dlvValid,
  input  logic                ackReq,
  input  logic                eoiReq,
  input  logic                tprWrEn,
  input  logic [TPR_IN_W-1:0] tprWrData,
  input  logic                svrWrEn,
  input  logic [SVR_W-1:0]    svrWrData,
  input  logic                initReq,
  input  logic [VEC_W-1:0]    irrTop,
  input  logic                irrValid,
  input  logic [VEC_W-1:0]    isrTop,
  input  logic                isrValid,
  input  logic                topLevel,
  output strobe_t             strb,
  output logic                intOut,
  output logic [VEC_W-1:0]    ackVector,
  output logic                ackLevel,
  output logic [VEC_W-1:0]    tprOut,
  output logic [VEC_W-1:0]    pprOut,
  output logic [SVR_W-1:0]    svrOut
);
  logic [VEC_W-1:0] tprReg;
  logic [SVR_W-1:0] svrReg;
  logic [VEC_W-1:0] isrCls, tprCls, pprVal;
  logic             spurHit;

  always_comb begin
    isrCls  = isrValid ? (isrTop & CLS_MASK) : '0;
    tprCls  = tprReg & CLS_MASK;
    pprVal  = (tprCls >= isrCls) ? tprReg : isrCls;
    spurHit = (tprReg != '0) && (irrTop <= tprReg);
  end

  always_comb begin
    strb.init     = initReq;
    strb.dlvDo    = dlvValid && !initReq;
    strb.ackTake  = ackReq && irrValid && !initReq;
    strb.ackToIsr = ackReq && irrValid && !initReq && !spurHit;
    strb.eoiDo    = eoiReq && isrValid && !initReq;
  end

  assign intOut    = svrReg[VEC_W] && irrValid &&
                     ((pprVal == '0) || ((irrTop & CLS_MASK) > (pprVal & CLS_MASK)));
  assign ackVector = (irrValid && !spurHit) ? irrTop : svrReg[VEC_W-1:0];
  assign ackLevel  = irrValid && !spurHit && topLevel;
  assign tprOut    = tprReg;
  assign pprOut    = pprVal;
  assign svrOut    = svrReg;

  always_ff @(posedge clk) begin
    if (!rstN || initReq) begin
      tprReg <= '0;
      svrReg <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      if (tprWrEn) tprReg <= {tprWrData, {CLASS_LSB{1'b0}}};
      if (svrWrEn) svrReg <= svrWrData;
    end
  end

  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> svrOut[VEC_W] && irrValid); // R3
  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    pprOut >= tprOut); // R8
  AST_TPR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tprOut & ~CLS_MASK) == '0); // R6
  AST_INIT_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> !svrOut[VEC_W] && (tprOut == '0) && !intOut); // R7
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
  import vec_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int CLASS_LSB = 4,
  localparam int VEC_W = $clog2(NUM_VEC),
  localparam int TPR_IN_W = VEC_W - CLASS_LSB,
  localparam int SVR_W = VEC_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dlvValid,
  input  logic [VEC_W-1:0]    dlvVector,
  input  logic                dlvLevel,
  input  logic                ackReq,
  output logic [VEC_W-1:0]    ackVector,
  output logic                ackLevel,
  input  logic                eoiReq,
  input  logic                tprWrEn,
  input  logic [TPR_IN_W-1:0] tprWrData,
  input  logic                svrWrEn,
  input  logic [SVR_W-1:0]    svrWrData,
  input  logic                initReq,
  output logic                intOut,
  output logic [VEC_W-1:0]    tprOut,
  output logic [VEC_W-1:0]    pprOut,
  output logic [SVR_W-1:0]    svrOut
);
  strobe_t          strb;
  logic [VEC_W-1:0] irrTop, isrTop;
  logic             irrValid, isrValid, topLevel;

  vec_prio_dp #(.NUM_VEC(NUM_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dlvVector(dlvVector), .dlvLevel(dlvLevel),
    .irrTop(irrTop), .irrValid(irrValid), .isrTop(isrTop), .isrValid(isrValid),
    .topLevel(topLevel)
  );

  vec_prio_ctrl #(.VEC_W(VEC_W), .CLASS_LSB(CLASS_LSB)) u_ctrl (
    .clk(clk), .rstN(rstN), .dlvValid(dlvValid), .ackReq(ackReq), .eoiReq(eoiReq),
    .tprWrEn(tprWrEn), .tprWrData(tprWrData), .svrWrEn(svrWrEn), .svrWrData(svrWrData),
    .initReq(initReq), .irrTop(irrTop), .irrValid(irrValid), .isrTop(isrTop),
    .isrValid(isrValid), .topLevel(topLevel), .strb(strb), .intOut(intOut),
    .ackVector(ackVector), .ackLevel(ackLevel), .tprOut(tprOut), .pprOut(pprOut),
    .svrOut(svrOut)
  );
endmodule

// File: tb/vec_prio_core_bench.sv
`timescale 1ns/1ps
module vec_prio_core_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic dlvValid = 0, dlvLevel = 0, ackReq = 0, eoiReq = 0, tprWrEn = 0, svrWrEn = 0, initReq = 0;
  logic [7:0] dlvVector = '0;
  logic [3:0] tprWrData = '0;
  logic [8:0] svrWrData = '0;
  logic [7:0] ackVector, tprOut, pprOut;
  logic       ackLevel, intOut;
  logic [8:0] svrOut;

  int passCnt = 0, totalCnt = 0;
  bit done = 0;
  logic [7:0] lastAck;
  logic       lastInt;

  bit [255:0] mIrr, mIsr, mTmr;
  bit [7:0]   mTpr;
  bit [8:0]   mSvr;

  always #2.5 clk = ~clk;

  vec_prio_core u_vec_prio_core (
    .clk(clk), .rstN(rstN), .dlvValid(dlvValid), .dlvVector(dlvVector), .dlvLevel(dlvLevel),
    .ackReq(ackReq), .ackVector(ackVector), .ackLevel(ackLevel), .eoiReq(eoiReq),
    .tprWrEn(tprWrEn), .tprWrData(tprWrData), .svrWrEn(svrWrEn), .svrWrData(svrWrData),
    .initReq(initReq), .intOut(intOut), .tprOut(tprOut), .pprOut(pprOut), .svrOut(svrOut)
  );

  function automatic int topOf(bit [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit [7:0] modelPpr();
    int s = topOf(mIsr);
    bit [7:0] ic = (s < 0) ? 8'h00 : (8'(s) & 8'hF0);
    return ((mTpr & 8'hF0) >= ic) ? mTpr : ic;
  endfunction

  function automatic bit modelSpur(int t);
    return (mTpr != 0) && (t >= 0) && (t <= int'(mTpr));
  endfunction

  function automatic bit modelInt();
    int t = topOf(mIrr);
    bit [7:0] p = modelPpr();
    if (!mSvr[8] || t < 0) return 1'b0;
    return (p == 0) || ((8'(t) & 8'hF0) > (p & 8'hF0));
  endfunction

  task automatic check(string tag, int act, int exp);
    totalCnt++;
    if (act == exp) passCnt++;
    else $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
  endtask

  task automatic modelReset();
    mIrr = '0; mIsr = '0; mTmr = '0; mTpr = '0; mSvr = 9'h0FF;
  endtask

  task automatic step(bit dv, bit [7:0] vec, bit lvl, bit ak, bit eo,
                      bit tw, bit [3:0] td, bit sw, bit [8:0] sd, bit in);
    int t, s;
    bit sp;
    dlvValid = dv; dlvVector = vec; dlvLevel = lvl; ackReq = ak; eoiReq = eo;
    tprWrEn = tw; tprWrData = td; svrWrEn = sw; svrWrData = sd; initReq = in;
    #1;
    t = topOf(mIrr); s = topOf(mIsr); sp = modelSpur(t);
    lastAck = ackVector; lastInt = intOut;
    check("R3 intOut", int'(intOut), int'(modelInt()));
    check("R8 pprOut", int'(pprOut), int'(modelPpr()));
    check("R6 tprOut", int'(tprOut), int'(mTpr));
    check("R10 svrOut", int'(svrOut), int'(mSvr));
    if (ak) begin
      check("R4 ackVector", int'(ackVector), (t >= 0 && !sp) ? t : int'(mSvr[7:0]));
      check("R1 ackLevel", int'(ackLevel), (t >= 0 && !sp) ? int'(mTmr[t]) : 0);
    end
    @(posedge clk);
    if (in) modelReset();
    else begin
      if (ak && t >= 0) mIrr[t] = 1'b0;
      if (eo && s >= 0) mIsr[s] = 1'b0;
      if (ak && t >= 0 && !sp) mIsr[t] = 1'b1;
      if (dv) begin mIrr[vec] = 1'b1; mTmr[vec] = lvl; end
      if (tw) mTpr = {td, 4'h0};
      if (sw) mSvr = sd;
    end
    @(negedge clk);
  endtask

  task automatic idle();            step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic deliver(bit [7:0] v, bit l); step(1, v, l, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic ack();             step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic eoi();             step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
  task automatic setTpr(bit [3:0] c); step(0, 0, 0, 0, 0, 1, c, 0, 0, 0); endtask
  task automatic setSvr(bit [8:0] d); step(0, 0, 0, 0, 0, 0, 0, 1, d, 0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    bit [7:0] pick [8] = '{8'h20, 8'h2F, 8'h30, 8'h50, 8'h51, 8'h5A, 8'h90, 8'hFF};
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    check("R11 intOut", int'(intOut), 0);
    check("R11 svrOut", int'(svrOut), 9'h0FF);
    check("R11 tprOut", int'(tprOut), 0);
    check("R11 pprOut", int'(pprOut), 0);
    @(negedge clk);

    // R3 disabled block keeps the line low
    deliver(8'h40, 0); idle();
    check("R3 disabled", int'(lastInt), 0);
    setSvr(9'h1E7); idle();
    check("R3 enabled", int'(lastInt), 1);
    // R2 highest-numbered wins, R1 level recorded
    deliver(8'h45, 1); deliver(8'h43, 0); ack();
    check("R2 highest", int'(lastAck), 8'h45);
    // R8 in-service class 4 raises ppr to 0x40; 0x43 same class: no interrupt
    idle();
    check("R8 ppr from isr", int'(pprOut), 8'h40);
    check("R3 same class blocked", int'(lastInt), 0);
    // R5 retire 0x45, then 0x43 pending again beats ppr 0
    eoi(); idle();
    check("R5 eoi", int'(pprOut), 8'h00);
    ack(); ack(); ack();
    check("R2 empty ack spurious", int'(lastAck), 8'hE7);
    eoi(); eoi(); eoi(); eoi();
    check("R5 eoi empty no effect", int'(pprOut), 8'h00);
    // R4 vector equal to task priority gives spurious
    setTpr(4'h5); deliver(8'h50, 0); ack();
    check("R4 at tpr spurious", int'(lastAck), 8'hE7);
    deliver(8'h51, 0); idle();
    check("R3 class equal to ppr blocked", int'(lastInt), 0);
    ack();
    check("R4 above tpr", int'(lastAck), 8'h51);
    eoi();
    // R9 delivery and ack on the same vector keeps the request
    setTpr(4'h0); deliver(8'h30, 0);
    step(1, 8'h30, 0, 1, 0, 0, 0, 0, 0, 0);
    ack();
    check("R9 redelivered", int'(lastAck), 8'h30);
    eoi(); eoi();
    // R7 init overrides a same-cycle delivery
    deliver(8'h77, 1);
    step(1, 8'h88, 0, 0, 0, 0, 0, 0, 0, 1);
    idle();
    check("R7 init disables", int'(svrOut), 9'h0FF);
    setSvr(9'h1AA); ack();
    check("R7 vectors cleared", int'(lastAck), 8'hAA);

    // Random traffic against the model
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      bit [7:0] v = ($urandom_range(0, 1) == 1) ? pick[$urandom_range(0, 7)] : 8'($urandom);
      step($urandom_range(0, 99) < 45, v, 1'($urandom),
           $urandom_range(0, 99) < 30, $urandom_range(0, 99) < 25,
           $urandom_range(0, 99) < 8, 4'($urandom),
           $urandom_range(0, 99) < 4, {$urandom_range(0, 9) != 0, 8'($urandom)},
           $urandom_range(0, 999) < 5);
    end

    done = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule